// File: doc/BRIEF.md
# Multi-vector MSI write generator

This block converts a vector of local interrupt request lines into Message Signaled Interrupt memory writes for a PCIe endpoint. Each request line is latched as a pending bit. The block picks one pending line by fixed priority and maps it onto one of the vectors that the host granted. It then forms the message data word and issues a single 32-bit write on a memory-mapped master port that uses waitrequest flow control. The write goes toward the transmit slave of the PCIe bridge.

Every vector goes to the same MSI address. Vectors differ only in their message data. The block reads the low bits of the base data from the configured value, then replaces as many of those bits as the Multiple Message Enable field grants with the vector number. Software sets the MSI enable bit. When that bit is clear, the block issues no writes. Instead it drives a level-type legacy interrupt line while any request is pending. Software then clears the serviced lines through a clear vector.

Top module: `msi_irq_gen`

## Requirements
- R1: The block sends every write to one shared address. When `cfg_addr_hi_i` is nonzero, it puts {hi,lo} on `avm_address_o` and drives `avm_addr64_o` high. Otherwise it puts {32'h0,lo} on the address and drives `avm_addr64_o` low.
- R2: Let n be `cfg_mme_i`. The message data is `cfg_data_i` with its low n bits replaced by the low n bits of the vector number. When n is 0, the data is `cfg_data_i` unchanged.
- R3: A `cfg_mme_i` value of 6 or 7 is treated as 5, which grants 32 vectors.
- R4: A request on line i maps to vector i when i is less than 2^n. Otherwise it maps to vector 2^n-1. One completed write for a vector clears every pending line that maps to that vector.
- R5: A pulse on `irq_req_i[i]` sets a sticky pending bit. In MSI mode, that bit clears only when a write completes, which means `avm_write_o` is high and `avm_waitrequest_i` is low on the same clock edge.
- R6: The lowest pending line index is served first. Only one write is outstanding at a time. `avm_write_o` drops in the cycle after a completion.
- R7: While `avm_waitrequest_i` holds a write, `avm_write_o`, `avm_address_o` and `avm_writedata_o` stay unchanged.
- R8: Every write has `avm_byteenable_o` = 4'b0011 and `avm_writedata_o[31:16]` = 0. The message data sits in bits 15:0.
- R9: While `cfg_msi_en_i` is low, no new write starts. In that state, `intx_o` is high exactly when any pending bit is set, and it is low whenever MSI is enabled.
- R10: `irq_clr_i[i]` clears pending bit i at the next edge. A new request on the same line in the same cycle wins, and the bit stays set.
- R11: During reset and right after it, `avm_write_o` and `intx_o` are low and no bit is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_req_i | input | REQ_W | Interrupt request pulses, one per line |
| irq_clr_i | input | REQ_W | Pending-bit clear, used for the legacy path |
| cfg_msi_en_i | input | 1 | MSI enable from configuration |
| cfg_mme_i | input | 3 | Granted vector count as log2 |
| cfg_addr_lo_i | input | 32 | MSI address, low word |
| cfg_addr_hi_i | input | 32 | MSI address, high word |
| cfg_data_i | input | 16 | MSI base message data |
| avm_address_o | output | 64 | Write address |
| avm_addr64_o | output | 1 | High when the address needs 64 bits |
| avm_write_o | output | 1 | Write request |
| avm_writedata_o | output | 32 | Write data |
| avm_byteenable_o | output | 4 | Byte enables |
| avm_waitrequest_i | input | 1 | Slave stall |
| intx_o | output | 1 | Legacy interrupt level |

## Verification
The bench drives one request at a time against every value of the Multiple Message Enable field, including the two reserved values. It uses a base data word whose low bits are set, so that a wrong mask width or a missing OR of the vector number shows up in the data. Some requests use line numbers above the granted count to separate folding from truncation. The high address word alternates between zero and nonzero to check the address-width choice. Simultaneous requests show the priority order. Folded duplicate requests must collapse into a single write. The legacy sequences exercise the set-versus-clear race and the handover from legacy mode back to MSI mode.

// File: rtl/msi_irq_pkg.sv
package msi_irq_pkg;
   localparam int VEC_W   = 5;   // an MSI function can address up to 32 vectors
   localparam int MSG_W   = 16;  // message data width
   localparam int LOG_MAX = 5;   // largest legal log2 vector count

   typedef enum logic {SEQ_IDLE, SEQ_BUSY} seq_state_t;

   // reserved field codes clamp to the largest legal count
   function automatic logic [2:0] eff_log2(input logic [2:0] mme);
      return (mme > 3'(LOG_MAX)) ? 3'(LOG_MAX) : mme;
   endfunction

   // map a request line onto a granted vector; over-requests land on the top one
   function automatic logic [VEC_W-1:0] fold_vec(input logic [VEC_W-1:0] line,
                                                 input logic [2:0] mme);
      logic [VEC_W:0] cnt;
      cnt = (VEC_W+1)'(1) << eff_log2(mme);
      if ({1'b0, line} >= cnt) return VEC_W'(cnt - 1'b1);
      return line;
   endfunction
endpackage

// File: rtl/msi_pend_arb.sv
module msi_pend_arb
   import msi_irq_pkg::*;
#(
   parameter int REQ_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [REQ_W-1:0] req_set,
   input  logic [REQ_W-1:0] req_clr,
   input  logic             done,
   input  logic [VEC_W-1:0] done_vec,
   input  logic [2:0]       mme,
   output logic             any_pend,
   output logic [REQ_W-1:0] pend,
   output logic [VEC_W-1:0] grant_vec
);
   logic [REQ_W-1:0] fold_hit;
   logic [VEC_W-1:0] grant_line;

   // lines that share the vector just delivered
   for (genvar j = 0; j < REQ_W; j++) begin : g_hit
      assign fold_hit[j] = done && (fold_vec(VEC_W'(j), mme) == done_vec);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend <= '0;
      else        pend <= (pend & ~(fold_hit | req_clr)) | req_set;
   end

   // fixed priority, line 0 first
   always_comb begin
      grant_line = '0;
      for (int i = REQ_W - 1; i >= 0; i--) begin
         if (pend[i]) grant_line = VEC_W'(i);
      end
   end

   assign any_pend  = |pend;
   assign grant_vec = fold_vec(grant_line, mme);
endmodule

// File: rtl/msi_msg_fmt.sv
module msi_msg_fmt
   import msi_irq_pkg::*;
#(
   parameter bit ADDR64_EN = 1'b1
) (
   input  logic [VEC_W-1:0] vec,
   input  logic [2:0]       mme,
   input  logic [MSG_W-1:0] base_data,
   input  logic [31:0]      addr_lo,
   input  logic [31:0]      addr_hi,
   output logic [MSG_W-1:0] msg_data,
   output logic [63:0]      addr,
   output logic             addr64
);
   logic [MSG_W-1:0] low_mask;

   assign low_mask = MSG_W'(((MSG_W+1)'(1) << eff_log2(mme)) - 1'b1);
   assign msg_data = (base_data & ~low_mask) | (MSG_W'(vec) & low_mask);

   if (ADDR64_EN) begin : g_addr64
      assign addr64 = |addr_hi;
      assign addr   = addr64 ? {addr_hi, addr_lo} : {32'h0, addr_lo};
   end else begin : g_addr32
      logic unused_hi;
      assign unused_hi = ^addr_hi;
      assign addr64    = 1'b0 & unused_hi;
      assign addr      = {32'h0, addr_lo};
   end
endmodule

// File: rtl/msi_wr_seq.sv
module msi_wr_seq
   import msi_irq_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             msi_en,
   input  logic             any_pend,
   input  logic [VEC_W-1:0] grant_vec,
   input  logic [MSG_W-1:0] msg_data,
   input  logic [63:0]      addr,
   input  logic             addr64,
   input  logic             waitreq,
   output logic             write,
   output logic [63:0]      wr_addr,
   output logic             wr_addr64,
   output logic [31:0]      wr_data,
   output logic [3:0]       wr_be,
   output logic             done,
   output logic [VEC_W-1:0] held_vec
);
   seq_state_t state;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= SEQ_IDLE;
         wr_addr   <= '0;
         wr_addr64 <= 1'b0;
         wr_data   <= '0;
         held_vec  <= '0;
      end else begin
         unique case (state)
            SEQ_IDLE: if (msi_en && any_pend) begin
               state     <= SEQ_BUSY;
               wr_addr   <= addr;
               wr_addr64 <= addr64;
               wr_data   <= {{(32-MSG_W){1'b0}}, msg_data};
               held_vec  <= grant_vec;
            end
            SEQ_BUSY: if (!waitreq) state <= SEQ_IDLE;
            default:  state <= SEQ_IDLE;
         endcase
      end
   end

   assign write = (state == SEQ_BUSY);
   assign done  = write && !waitreq;
   assign wr_be = 4'b0011;
endmodule

// File: rtl/msi_irq_gen.sv
module msi_irq_gen
   import msi_irq_pkg::*;
#(
   parameter int REQ_W     = 8,
   parameter bit ADDR64_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [REQ_W-1:0] irq_req_i,
   input  logic [REQ_W-1:0] irq_clr_i,
   input  logic             cfg_msi_en_i,
   input  logic [2:0]       cfg_mme_i,
   input  logic [31:0]      cfg_addr_lo_i,
   input  logic [31:0]      cfg_addr_hi_i,
   input  logic [15:0]      cfg_data_i,
   output logic [63:0]      avm_address_o,
   output logic             avm_addr64_o,
   output logic             avm_write_o,
   output logic [31:0]      avm_writedata_o,
   output logic [3:0]       avm_byteenable_o,
   input  logic             avm_waitrequest_i,
   output logic             intx_o
);
   if (REQ_W < 1 || REQ_W > (1 << VEC_W)) begin : g_bad_req_w
      $error("msi_irq_gen: REQ_W must lie in 1..32");
   end

   logic             any_pend, done;
   logic [REQ_W-1:0] pend;
   logic [VEC_W-1:0] grant_vec, held_vec;
   logic [MSG_W-1:0] msg_data;
   logic [63:0]      addr;
   logic             addr64;

   msi_pend_arb #(.REQ_W(REQ_W)) u_arb (
      .clk(clk), .rst_n(rst_n), .req_set(irq_req_i), .req_clr(irq_clr_i),
      .done(done), .done_vec(held_vec), .mme(cfg_mme_i),
      .any_pend(any_pend), .pend(pend), .grant_vec(grant_vec));

   msi_msg_fmt #(.ADDR64_EN(ADDR64_EN)) u_fmt (
      .vec(grant_vec), .mme(cfg_mme_i), .base_data(cfg_data_i),
      .addr_lo(cfg_addr_lo_i), .addr_hi(cfg_addr_hi_i),
      .msg_data(msg_data), .addr(addr), .addr64(addr64));

   msi_wr_seq u_seq (
      .clk(clk), .rst_n(rst_n), .msi_en(cfg_msi_en_i), .any_pend(any_pend),
      .grant_vec(grant_vec), .msg_data(msg_data), .addr(addr), .addr64(addr64),
      .waitreq(avm_waitrequest_i), .write(avm_write_o), .wr_addr(avm_address_o),
      .wr_addr64(avm_addr64_o), .wr_data(avm_writedata_o), .wr_be(avm_byteenable_o),
      .done(done), .held_vec(held_vec));

   assign intx_o = !cfg_msi_en_i && (|pend);
endmodule

// File: rtl/msi_irq_gen_chk.sv
module msi_irq_gen_chk #(
   parameter int REQ_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic [REQ_W-1:0] irq_clr_i,
   input logic             cfg_msi_en_i,
   input logic [63:0]      avm_address_o,
   input logic             avm_addr64_o,
   input logic             avm_write_o,
   input logic [31:0]      avm_writedata_o,
   input logic [3:0]       avm_byteenable_o,
   input logic             avm_waitrequest_i,
   input logic             intx_o
);
   assert_addr_width_R1: assert property (@(posedge clk) disable iff (!rst_n)
      avm_write_o |-> (avm_addr64_o == (avm_address_o[63:32] != 32'h0)));

   assert_byte_lanes_R8: assert property (@(posedge clk) disable iff (!rst_n)
      avm_write_o |-> (avm_byteenable_o == 4'b0011 && avm_writedata_o[31:16] == 16'h0));

   assert_hold_on_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (avm_write_o && avm_waitrequest_i) |=>
         (avm_write_o && $stable(avm_address_o) && $stable(avm_writedata_o)));

   assert_single_flight_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (avm_write_o && !avm_waitrequest_i) |=> !avm_write_o);

   assert_no_start_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(avm_write_o) |-> $past(cfg_msi_en_i));

   assert_legacy_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_msi_en_i && $past(!cfg_msi_en_i) && $past(intx_o) && $past(irq_clr_i) == '0)
         |-> intx_o);

   assert_legacy_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_msi_en_i |-> !intx_o);
endmodule

bind msi_irq_gen msi_irq_gen_chk #(.REQ_W(REQ_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .irq_clr_i(irq_clr_i), .cfg_msi_en_i(cfg_msi_en_i),
   .avm_address_o(avm_address_o), .avm_addr64_o(avm_addr64_o),
   .avm_write_o(avm_write_o), .avm_writedata_o(avm_writedata_o),
   .avm_byteenable_o(avm_byteenable_o), .avm_waitrequest_i(avm_waitrequest_i),
   .intx_o(intx_o));

// File: tb/msi_irq_gen_test.sv
`timescale 1ns/1ps
module msi_irq_gen_test;
   localparam int REQ_W = 8;
   localparam logic [31:0] ADDR_LO = 32'hFEE0_1000;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [REQ_W-1:0] irq_req_i = '0;
   logic [REQ_W-1:0] irq_clr_i = '0;
   logic             cfg_msi_en_i = 1'b1;
   logic [2:0]       cfg_mme_i = '0;
   logic [31:0]      cfg_addr_lo_i = ADDR_LO;
   logic [31:0]      cfg_addr_hi_i = '0;
   logic [15:0]      cfg_data_i = '0;
   logic [63:0]      avm_address_o;
   logic             avm_addr64_o;
   logic             avm_write_o;
   logic [31:0]      avm_writedata_o;
   logic [3:0]       avm_byteenable_o;
   logic             avm_waitrequest_i = 1'b0;
   logic             intx_o;

   int  n_checks = 0;
   int  n_fail   = 0;
   bit  finished = 0;

   logic [63:0] cap_addr;
   logic [31:0] cap_data;
   logic [3:0]  cap_be;
   logic        cap_a64;

   always #4 clk = ~clk;   // 125 MHz

   msi_irq_gen #(.REQ_W(REQ_W)) uut (.*);

   typedef struct packed {
      logic [2:0]  mme;
      logic [15:0] base;
      logic [4:0]  line;
      logic [31:0] hi;
      logic [15:0] exp;
   } row_t;

   localparam row_t TBL [12] = '{
      '{3'd0, 16'h4321, 5'd5, 32'h0,         16'h4321},
      '{3'd1, 16'h12FF, 5'd0, 32'h0,         16'h12FE},
      '{3'd1, 16'h12FF, 5'd1, 32'h0000_0001, 16'h12FF},
      '{3'd1, 16'h12FF, 5'd6, 32'h0,         16'h12FF},
      '{3'd2, 16'h12FF, 5'd2, 32'h0,         16'h12FE},
      '{3'd2, 16'h12FF, 5'd7, 32'hABCD_0000, 16'h12FF},
      '{3'd3, 16'h5A5B, 5'd5, 32'h0,         16'h5A5D},
      '{3'd3, 16'h5A5B, 5'd0, 32'h0000_0001, 16'h5A58},
      '{3'd4, 16'hABCD, 5'd7, 32'h0,         16'hABC7},
      '{3'd5, 16'h00E0, 5'd7, 32'h0,         16'h00E7},
      '{3'd6, 16'h0040, 5'd3, 32'h0,         16'h0043},
      '{3'd7, 16'hFFFF, 5'd6, 32'h0,         16'hFFE6}
   };

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // wait for one write to complete under random stalls; captures its fields
   task automatic take_write(output bit got);
      got = 0;
      for (int k = 0; k < 200 && !got; k++) begin
         @(negedge clk);
         avm_waitrequest_i = ($urandom_range(0, 2) == 0);
         #1;
         if (avm_write_o && !avm_waitrequest_i) begin
            cap_addr = avm_address_o;
            cap_data = avm_writedata_o;
            cap_be   = avm_byteenable_o;
            cap_a64  = avm_addr64_o;
            got      = 1;
         end
      end
      @(negedge clk);
      avm_waitrequest_i = 1'b0;
   endtask

   task automatic count_writes(input int cycles, output int cnt);
      cnt = 0;
      for (int k = 0; k < cycles; k++) begin
         @(negedge clk);
         avm_waitrequest_i = 1'b0;
         #1;
         if (avm_write_o) cnt++;
      end
   endtask

   task automatic pulse_req(input logic [REQ_W-1:0] bits);
      @(negedge clk);
      irq_req_i = bits;
      @(negedge clk);
      irq_req_i = '0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      bit got;
      int cnt;
      logic [15:0] first_data;

      // R11: reset state
      repeat (3) @(negedge clk);
      check(!avm_write_o && !intx_o, "R11 write/intx in reset", {avm_write_o, intx_o}, 0);
      rst_n = 1'b1;
      count_writes(4, cnt);
      check(cnt == 0 && !intx_o, "R11 idle after reset", cnt, 0);

      // R1 R2 R3 R4 R8: table walk
      for (int r = 0; r < 12; r++) begin
         @(negedge clk);
         cfg_mme_i     = TBL[r].mme;
         cfg_data_i    = TBL[r].base;
         cfg_addr_hi_i = TBL[r].hi;
         pulse_req(REQ_W'(1) << TBL[r].line);
         take_write(got);
         check(got, "R5 write delivered", got, 1);
         check(cap_data == {16'h0, TBL[r].exp}, "R2/R3/R4 message data", cap_data,
               {16'h0, TBL[r].exp});
         check(cap_addr == (TBL[r].hi != 0 ? {TBL[r].hi, ADDR_LO} : {32'h0, ADDR_LO}),
               "R1 address", cap_addr, {TBL[r].hi, ADDR_LO});
         check(cap_a64 == (TBL[r].hi != 0), "R1 address width flag", cap_a64, TBL[r].hi != 0);
         check(cap_be == 4'b0011, "R8 byte enables", cap_be, 4'b0011);
      end
      cfg_addr_hi_i = '0;

      // R6: simultaneous lines 5 and 2, line 2 first
      @(negedge clk);
      cfg_mme_i  = 3'd3;
      cfg_data_i = 16'h5A5B;
      pulse_req(8'b0010_0100);
      take_write(got);
      first_data = cap_data[15:0];
      check(first_data == 16'h5A5A, "R6 priority first", first_data, 16'h5A5A);
      take_write(got);
      check(got && cap_data[15:0] == 16'h5A5D, "R6 priority second", cap_data, 16'h5A5D);

      // R4: lines 1,4,6 all fold to vector 1 -> exactly one write
      @(negedge clk);
      cfg_mme_i  = 3'd1;
      cfg_data_i = 16'h12FF;
      pulse_req(8'b0101_0010);
      take_write(got);
      check(got && cap_data[15:0] == 16'h12FF, "R4 folded data", cap_data, 16'h12FF);
      count_writes(12, cnt);
      check(cnt == 0, "R4 one write per vector", cnt, 0);

      // R9 R10: legacy path
      @(negedge clk);
      cfg_msi_en_i = 1'b0;
      pulse_req(8'b0000_1000);
      #1;
      check(intx_o, "R9 intx on pending", intx_o, 1);
      count_writes(10, cnt);
      check(cnt == 0 && intx_o, "R9 no write while disabled", cnt, 0);
      // R10: clear and request together -> stays pending
      @(negedge clk);
      irq_clr_i = 8'b0000_1000;
      irq_req_i = 8'b0000_1000;
      @(negedge clk);
      irq_clr_i = '0;
      irq_req_i = '0;
      #1;
      check(intx_o, "R10 set wins over clear", intx_o, 1);
      @(negedge clk);
      irq_clr_i = 8'b0000_1000;
      @(negedge clk);
      irq_clr_i = '0;
      #1;
      check(!intx_o, "R10 clear drops intx", intx_o, 0);
      cfg_msi_en_i = 1'b1;
      count_writes(10, cnt);
      check(cnt == 0, "R10 cleared line sends nothing", cnt, 0);

      // R5: pending survives legacy period, then goes out once enabled
      @(negedge clk);
      cfg_msi_en_i = 1'b0;
      cfg_mme_i    = 3'd3;
      cfg_data_i   = 16'h5A5B;
      pulse_req(8'b0001_0000);
      repeat (5) @(negedge clk);
      #1;
      check(intx_o, "R5 pending held in legacy", intx_o, 1);
      cfg_msi_en_i = 1'b1;
      #1;
      check(!intx_o, "R9 intx low when enabled", intx_o, 0);
      take_write(got);
      check(got && cap_data[15:0] == 16'h5A5C, "R5 deferred write", cap_data, 16'h5A5C);
      count_writes(8, cnt);
      check(cnt == 0, "R5 cleared on completion", cnt, 0);

      // R5 R7: long stall keeps the write presented and unchanged
      @(negedge clk);
      avm_waitrequest_i = 1'b1;
      irq_req_i = 8'b0000_0001;
      @(negedge clk);
      irq_req_i = '0;
      @(negedge clk);
      #1;
      first_data = avm_writedata_o[15:0];
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         #1;
         check(avm_write_o && avm_writedata_o[15:0] == first_data, "R7 held under stall",
               avm_writedata_o, first_data);
      end
      check(first_data == 16'h5A58, "R2 stalled data", first_data, 16'h5A58);
      @(negedge clk);
      avm_waitrequest_i = 1'b0;
      @(negedge clk);
      #1;
      check(!avm_write_o, "R6 write drops after completion", avm_write_o, 0);

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule